// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This controller steps an external analog-to-digital converter through two programmable channel lists. The regular list holds up to eight entries and feeds a single result register. Each regular result comes with a one-cycle DMA request, so that a DMA engine can drain the register before the next result overwrites it. The inserted list holds up to four entries. It has priority over the regular list, and each of its results lands in a register of its own, one per list slot.

Either list starts on a software start pulse or on a rising edge of its external trigger, when that trigger is enabled. Before each conversion the sequencer waits a programmable sample time, looked up per channel. It then holds a convert request until the converter returns a done pulse with data. When a list completes, its end flag is set. An interrupt line per flag follows the flag, gated by an enable. Software clears a flag with a one-cycle clear pulse; this is the write-0 action. In continuous mode the regular list starts over from its first entry with no new trigger.

Top module: `adc_scan_seq`

## Requirements
- R1: While rst_ni is low, conv_req_o, dma_req_o, both end flags, both interrupt outputs, reg_data_o and ins_data_o are all zero.
- R2: A regular scan converts reg_len_i+1 channels (1 to 8). Entry k is taken from reg_chans_i[4k+3:4k], and the entries run from k=0 upward; conv_ch_o carries the entry while conv_req_o is high.
- R3: An inserted scan converts ins_len_i+1 channels (1 to 4), with entry k taken from ins_chans_i[4k+3:4k]. The result of entry k is stored in ins_data_o[12k+11:12k], and the other slots keep their values.
- R4: Each regular result is written to reg_data_o in the cycle after the done handshake, with dma_req_o high for exactly that one cycle. Inserted results raise no DMA request.
- R5: eoc_o is set after the last regular entry completes, and eoic_o after the last inserted entry. Neither is set earlier. A one-cycle pulse on eoc_clr_i or eoic_clr_i clears the matching flag.
- R6: eoc_irq_o is high only while eoc_o and eoc_ie_i are both high. eoic_irq_o likewise follows eoic_o and eoic_ie_i.
- R7: With cont_i high, the regular scan restarts at entry 0 after its last entry, with no new trigger. After cont_i drops, the scan stops at the end of the current pass.
- R8: A start pulse or a rising edge of the external trigger, when its enable is high, starts a scan. A trigger held high does not start another scan, and an edge that arrives while the enable is low is ignored.
- R9: An inserted trigger that arrives during a regular scan is served once the current conversion completes. The regular scan then resumes at its next entry.
- R10: Within a scan, conv_req_o stays low for exactly code+2 cycles between a done handshake and the next request. Here code is smp_code_i[4c+3:4c] for the next channel c.
- R11: Triggers that arrive while en_i is low have no effect, even after en_i returns high.
- R12: conv_ch_o holds its value while conv_req_o is high and done has not been returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable |
| cont_i | input | 1 | Regular continuous mode |
| reg_len_i | input | 3 | Regular list length minus one |
| reg_chans_i | input | 32 | Regular channel list, 4 bits per entry |
| ins_len_i | input | 2 | Inserted list length minus one |
| ins_chans_i | input | 16 | Inserted channel list, 4 bits per entry |
| smp_code_i | input | 64 | Sample-time code per channel, 4 bits each |
| reg_sw_start_i | input | 1 | Regular software start pulse |
| reg_ext_en_i | input | 1 | Regular external trigger enable |
| reg_ext_trig_i | input | 1 | Regular external trigger |
| ins_sw_start_i | input | 1 | Inserted software start pulse |
| ins_ext_en_i | input | 1 | Inserted external trigger enable |
| ins_ext_trig_i | input | 1 | Inserted external trigger |
| eoc_ie_i | input | 1 | Regular end interrupt enable |
| eoic_ie_i | input | 1 | Inserted end interrupt enable |
| eoc_clr_i | input | 1 | Clear pulse for eoc_o |
| eoic_clr_i | input | 1 | Clear pulse for eoic_o |
| conv_req_o | output | 1 | Convert request to the converter |
| conv_ch_o | output | 4 | Channel to convert |
| conv_done_i | input | 1 | Conversion done pulse |
| conv_data_i | input | 12 | Conversion result |
| reg_data_o | output | 12 | Regular result register |
| dma_req_o | output | 1 | DMA request pulse |
| ins_data_o | output | 48 | Inserted result registers, 12 bits per slot |
| eoc_o | output | 1 | Regular end flag |
| eoic_o | output | 1 | Inserted end flag |
| eoc_irq_o | output | 1 | Regular end interrupt |
| eoic_irq_o | output | 1 | Inserted end interrupt |

## Verification
The assertions check every cycle that conv_ch_o holds steady during a request and that sample timing matches the code of the channel being launched. They also check that DMA pulses and end flags appear only after a done handshake, that a regular launch never passes a pending inserted group, and that nothing launches while the converter is disabled. Only the scenarios can show the full conversion order: channel lists of several lengths, inserted preemption in the middle of a scan, continuous restart and its stop, and the routing of results to slots. They also show edge-only triggering, and that triggers are dropped while the enable is low.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONV} seq_st_e;
  typedef enum logic {GRP_REG, GRP_INS} grp_e;
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sw_i,
  input  logic ext_en_i,
  input  logic ext_i,
  input  logic ack_i,
  output logic pend_o
);
  logic ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      ext_q <= ext_i;
      if (!en_i)                                   pend_o <= 1'b0;
      else if (sw_i || (ext_en_i && ext_i && !ext_q)) pend_o <= 1'b1;
      else if (ack_i)                              pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int SW   = 4,
  parameter int RLEN = 8,
  parameter int ILEN = 4,
  localparam int CHW = $clog2(NCH),
  localparam int RIW = $clog2(RLEN),
  localparam int ILW = $clog2(ILEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cont_i,
  input  logic [RIW-1:0]    reg_len_i,
  input  logic [RLEN*CHW-1:0] reg_chans_i,
  input  logic [ILW-1:0]    ins_len_i,
  input  logic [ILEN*CHW-1:0] ins_chans_i,
  input  logic [NCH*SW-1:0] smp_code_i,
  input  logic              reg_pend_i,
  input  logic              ins_pend_i,
  input  logic              conv_done_i,
  output logic              reg_ack_o,
  output logic              ins_ack_o,
  output logic              conv_req_o,
  output logic [CHW-1:0]    conv_ch_o,
  output logic              store_o,
  output grp_e              store_grp_o,
  output logic [ILW-1:0]    store_slot_o,
  output logic              reg_last_o,
  output logic              ins_last_o,
  output logic              launch_o,
  output logic              launch_reg_o,
  output logic              idle_o,
  output logic              ins_act_o,
  output logic [RIW-1:0]    reg_idx_o
);
  seq_st_e        st;
  grp_e           cur_grp;
  logic [CHW-1:0] cur_ch;
  logic [SW-1:0]  cnt;
  logic [RIW-1:0] reg_idx;
  logic [ILW-1:0] ins_idx;
  logic           reg_act, ins_act;
  logic           pick_ins, pick_reg;
  logic [CHW-1:0] sel_ch;

  // inserted work always wins at a selection point
  assign pick_ins = en_i && (ins_act || ins_pend_i);
  assign pick_reg = en_i && !pick_ins && (reg_act || reg_pend_i);
  assign idle_o   = (st == ST_IDLE);
  assign launch_o = idle_o && (pick_ins || pick_reg);
  assign launch_reg_o = idle_o && pick_reg;
  assign ins_ack_o = idle_o && pick_ins && !ins_act;
  assign reg_ack_o = idle_o && pick_reg && !reg_act;
  assign sel_ch = pick_ins ? ins_chans_i[ins_idx*CHW +: CHW]
                           : reg_chans_i[reg_idx*CHW +: CHW];

  assign reg_last_o   = (reg_idx == reg_len_i);
  assign ins_last_o   = (ins_idx == ins_len_i);
  assign conv_req_o   = (st == ST_CONV);
  assign conv_ch_o    = cur_ch;
  assign store_o      = conv_req_o && conv_done_i;
  assign store_grp_o  = cur_grp;
  assign store_slot_o = ins_idx;
  assign ins_act_o    = ins_act;
  assign reg_idx_o    = reg_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      cur_grp <= GRP_REG;
      cur_ch  <= '0;
      cnt     <= '0;
      reg_idx <= '0;
      ins_idx <= '0;
      reg_act <= 1'b0;
      ins_act <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (launch_o) begin
          cur_grp <= pick_ins ? GRP_INS : GRP_REG;
          cur_ch  <= sel_ch;
          cnt     <= smp_code_i[sel_ch*SW +: SW];
          if (pick_ins) ins_act <= 1'b1;
          else          reg_act <= 1'b1;
          st <= ST_SAMPLE;
        end
        ST_SAMPLE: begin
          if (cnt == '0) st <= ST_CONV;
          else           cnt <= cnt - 1'b1;
        end
        ST_CONV: if (conv_done_i) begin
          st <= ST_IDLE;
          if (cur_grp == GRP_INS) begin
            if (ins_last_o) begin
              ins_act <= 1'b0;
              ins_idx <= '0;
            end else ins_idx <= ins_idx + 1'b1;
          end else begin
            if (reg_last_o) begin
              reg_idx <= '0;
              if (!cont_i) reg_act <= 1'b0;
            end else reg_idx <= reg_idx + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results
  import adc_seq_pkg::*;
#(
  parameter int DW   = 12,
  parameter int ILEN = 4,
  localparam int ILW = $clog2(ILEN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               store_i,
  input  grp_e               grp_i,
  input  logic [ILW-1:0]     slot_i,
  input  logic               reg_last_i,
  input  logic               ins_last_i,
  input  logic [DW-1:0]      data_i,
  input  logic               eoc_clr_i,
  input  logic               eoic_clr_i,
  input  logic               eoc_ie_i,
  input  logic               eoic_ie_i,
  output logic [DW-1:0]      reg_data_o,
  output logic [ILEN*DW-1:0] ins_data_o,
  output logic               dma_req_o,
  output logic               eoc_o,
  output logic               eoic_o,
  output logic               eoc_irq_o,
  output logic               eoic_irq_o
);
  logic st_reg, st_ins;

  assign st_reg = store_i && (grp_i == GRP_REG);
  assign st_ins = store_i && (grp_i == GRP_INS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_data_o <= '0;
      dma_req_o  <= 1'b0;
      eoc_o      <= 1'b0;
      eoic_o     <= 1'b0;
    end else begin
      dma_req_o <= st_reg;
      if (st_reg) reg_data_o <= data_i;
      // set beats clear in the same cycle
      if (st_reg && reg_last_i) eoc_o <= 1'b1;
      else if (eoc_clr_i)       eoc_o <= 1'b0;
      if (st_ins && ins_last_i) eoic_o <= 1'b1;
      else if (eoic_clr_i)      eoic_o <= 1'b0;
    end
  end

  for (genvar g = 0; g < ILEN; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               ins_data_o[g*DW +: DW] <= '0;
      else if (st_ins && (slot_i == ILW'(g)))   ins_data_o[g*DW +: DW] <= data_i;
    end
  end

  assign eoc_irq_o  = eoc_o && eoc_ie_i;
  assign eoic_irq_o = eoic_o && eoic_ie_i;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int SW   = 4,
  parameter int DW   = 12,
  parameter int RLEN = 8,
  parameter int ILEN = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic                          cont_i,
  input  logic [$clog2(RLEN)-1:0]       reg_len_i,
  input  logic [RLEN*$clog2(NCH)-1:0]   reg_chans_i,
  input  logic [$clog2(ILEN)-1:0]       ins_len_i,
  input  logic [ILEN*$clog2(NCH)-1:0]   ins_chans_i,
  input  logic [NCH*SW-1:0]             smp_code_i,
  input  logic                          reg_sw_start_i,
  input  logic                          reg_ext_en_i,
  input  logic                          reg_ext_trig_i,
  input  logic                          ins_sw_start_i,
  input  logic                          ins_ext_en_i,
  input  logic                          ins_ext_trig_i,
  input  logic                          eoc_ie_i,
  input  logic                          eoic_ie_i,
  input  logic                          eoc_clr_i,
  input  logic                          eoic_clr_i,
  output logic                          conv_req_o,
  output logic [$clog2(NCH)-1:0]        conv_ch_o,
  input  logic                          conv_done_i,
  input  logic [DW-1:0]                 conv_data_i,
  output logic [DW-1:0]                 reg_data_o,
  output logic                          dma_req_o,
  output logic [ILEN*DW-1:0]            ins_data_o,
  output logic                          eoc_o,
  output logic                          eoic_o,
  output logic                          eoc_irq_o,
  output logic                          eoic_irq_o
);
  localparam int RIW = $clog2(RLEN);
  localparam int ILW = $clog2(ILEN);

  logic           reg_pend, ins_pend, reg_ack, ins_ack;
  logic           store, reg_last, ins_last;
  grp_e           store_grp;
  logic [ILW-1:0] store_slot;
  logic           launch, launch_reg, seq_idle, ins_act;
  logic [RIW-1:0] reg_idx;

  adc_seq_trig u_reg_trig (
    .clk_i, .rst_ni, .en_i,
    .sw_i(reg_sw_start_i), .ext_en_i(reg_ext_en_i), .ext_i(reg_ext_trig_i),
    .ack_i(reg_ack), .pend_o(reg_pend)
  );

  adc_seq_trig u_ins_trig (
    .clk_i, .rst_ni, .en_i,
    .sw_i(ins_sw_start_i), .ext_en_i(ins_ext_en_i), .ext_i(ins_ext_trig_i),
    .ack_i(ins_ack), .pend_o(ins_pend)
  );

  adc_seq_ctrl #(.NCH(NCH), .SW(SW), .RLEN(RLEN), .ILEN(ILEN)) u_ctrl (
    .clk_i, .rst_ni, .en_i, .cont_i,
    .reg_len_i, .reg_chans_i, .ins_len_i, .ins_chans_i, .smp_code_i,
    .reg_pend_i(reg_pend), .ins_pend_i(ins_pend), .conv_done_i,
    .reg_ack_o(reg_ack), .ins_ack_o(ins_ack),
    .conv_req_o, .conv_ch_o,
    .store_o(store), .store_grp_o(store_grp), .store_slot_o(store_slot),
    .reg_last_o(reg_last), .ins_last_o(ins_last),
    .launch_o(launch), .launch_reg_o(launch_reg), .idle_o(seq_idle),
    .ins_act_o(ins_act), .reg_idx_o(reg_idx)
  );

  adc_seq_results #(.DW(DW), .ILEN(ILEN)) u_res (
    .clk_i, .rst_ni,
    .store_i(store), .grp_i(store_grp), .slot_i(store_slot),
    .reg_last_i(reg_last), .ins_last_i(ins_last), .data_i(conv_data_i),
    .eoc_clr_i, .eoic_clr_i, .eoc_ie_i, .eoic_ie_i,
    .reg_data_o, .ins_data_o, .dma_req_o,
    .eoc_o, .eoic_o, .eoc_irq_o, .eoic_irq_o
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NCH  = 16,
  parameter int SW   = 4,
  parameter int RLEN = 8,
  localparam int CHW = $clog2(NCH),
  localparam int RIW = $clog2(RLEN)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [RIW-1:0]    reg_len_i,
  input logic [NCH*SW-1:0] smp_code_i,
  input logic              conv_req_o,
  input logic [CHW-1:0]    conv_ch_o,
  input logic              conv_done_i,
  input logic              dma_req_o,
  input logic              eoc_o,
  input logic              eoic_o,
  input logic              launch_i,
  input logic              launch_reg_i,
  input logic              idle_i,
  input logic              ins_pend_i,
  input logic              ins_act_i,
  input logic [RIW-1:0]    reg_idx_i
);
  logic [7:0] gap;
  logic       armed;
  logic [SW-1:0] cur_code;

  assign cur_code = smp_code_i[conv_ch_o*SW +: SW];

  // low-cycle counter between a handshake and the next request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap   <= '0;
      armed <= 1'b0;
    end else if (conv_req_o && conv_done_i) begin
      gap   <= '0;
      armed <= 1'b1;
    end else begin
      if (!conv_req_o) gap <= gap + 8'd1;
      if (idle_i && !launch_i) armed <= 1'b0;
    end
  end

  a_r10_sample_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(conv_req_o) && armed) |-> (gap == 8'(cur_code) + 8'd2));

  a_r12_ch_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && !conv_done_i) |=> $stable(conv_ch_o));

  a_r4_dma_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> $past(conv_req_o && conv_done_i));

  a_r5_eoc_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc_o) |-> $past(conv_req_o && conv_done_i));

  a_r5_eoic_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoic_o) |-> $past(conv_req_o && conv_done_i));

  a_r9_ins_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_reg_i |-> (!ins_pend_i && !ins_act_i));

  a_r11_no_launch_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !launch_i);

  a_r2_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_idx_i <= reg_len_i);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH), .SW(SW), .RLEN(RLEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .reg_len_i(reg_len_i),
  .smp_code_i(smp_code_i), .conv_req_o(conv_req_o), .conv_ch_o(conv_ch_o),
  .conv_done_i(conv_done_i), .dma_req_o(dma_req_o), .eoc_o(eoc_o), .eoic_o(eoic_o),
  .launch_i(launch), .launch_reg_i(launch_reg), .idle_i(seq_idle),
  .ins_pend_i(ins_pend), .ins_act_i(ins_act), .reg_idx_i(reg_idx)
);

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16, SW = 4, DW = 12, RLEN = 8, ILEN = 4, CHW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic en_i = 1'b1, cont_i = 1'b0;
  logic [2:0] reg_len_i = '0;
  logic [RLEN*CHW-1:0] reg_chans_i;
  logic [1:0] ins_len_i = '0;
  logic [ILEN*CHW-1:0] ins_chans_i;
  logic [NCH*SW-1:0] smp_code_i;
  logic reg_sw_start_i = 0, reg_ext_en_i = 0, reg_ext_trig_i = 0;
  logic ins_sw_start_i = 0, ins_ext_en_i = 0, ins_ext_trig_i = 0;
  logic eoc_ie_i = 0, eoic_ie_i = 0, eoc_clr_i = 0, eoic_clr_i = 0;
  logic conv_req_o;
  logic [CHW-1:0] conv_ch_o;
  logic conv_done_i = 1'b0;
  logic [DW-1:0] conv_data_i = '0;
  logic [DW-1:0] reg_data_o;
  logic dma_req_o;
  logic [ILEN*DW-1:0] ins_data_o;
  logic eoc_o, eoic_o, eoc_irq_o, eoic_irq_o;

  adc_scan_seq u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {bit ins; int slot; int ch;} item_t;
  item_t exp_q[$];
  int n_checks = 0, n_err = 0;
  int rlist[8] = '{5, 9, 2, 14, 0, 7, 11, 3};
  int ilist[4] = '{12, 1, 8, 6};
  int done_cnt = 0, req_rises = 0, seqn = 0, gap = 0, wcnt = 0;
  bit chain = 0, prev_req = 0, pend_chk = 0, finished = 0;
  int rise_ch = 0;
  item_t pend_item;
  logic [DW-1:0] pend_data;

  function automatic int code_of(int ch);
    return (ch * 5) % 11;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv, input string what);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push_reg(input int first, input int n);
    for (int k = first; k < first + n; k++) exp_q.push_back('{0, k, rlist[k]});
  endtask

  task automatic push_ins(input int first, input int n);
    for (int k = first; k < first + n; k++) exp_q.push_back('{1, k, ilist[k]});
  endtask

  // converter model + monitor: done 3 cycles after each request
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (pend_chk) begin
        if (pend_item.ins) begin
          check(dma_req_o == 1'b0, "R4", int'(dma_req_o), 0, "dma on inserted result");
          check(ins_data_o[pend_item.slot*DW +: DW] == pend_data, "R3",
                int'(ins_data_o[pend_item.slot*DW +: DW]), int'(pend_data), "inserted slot data");
        end else begin
          check(dma_req_o == 1'b1, "R4", int'(dma_req_o), 1, "dma pulse");
          check(reg_data_o == pend_data, "R4", int'(reg_data_o), int'(pend_data), "regular data");
        end
        pend_chk = 0;
      end else if (dma_req_o) check(0, "R4", 1, 0, "stray dma pulse");
      if (conv_done_i) begin
        conv_done_i = 1'b0;
      end else if (conv_req_o) begin
        if (!prev_req) begin
          req_rises++;
          rise_ch = int'(conv_ch_o);
          if (chain) check(gap == code_of(int'(conv_ch_o)) + 2, "R10", gap,
                           code_of(int'(conv_ch_o)) + 2, "sample gap");
        end
        wcnt++;
        if (wcnt == 3) begin
          check(int'(conv_ch_o) == rise_ch, "R12", int'(conv_ch_o), rise_ch, "channel held");
          pend_data = DW'((int'(conv_ch_o) << 8) | (seqn & 255));
          if (exp_q.size() == 0) begin
            check(0, "R2", int'(conv_ch_o), -1, "unexpected conversion");
          end else begin
            pend_item = exp_q.pop_front();
            check(int'(conv_ch_o) == pend_item.ch, pend_item.ins ? "R3" : "R2",
                  int'(conv_ch_o), pend_item.ch, "channel order");
            pend_chk = 1;
          end
          conv_data_i = pend_data;
          conv_done_i = 1'b1;
          chain = exp_q.size() > 0;
          done_cnt++;
          seqn++;
          wcnt = 0;
          gap = 0;
        end
      end
      if (!conv_req_o) gap++;
      prev_req = conv_req_o;
    end
  end

  task automatic wait_drain();
    int t = 0;
    while ((exp_q.size() != 0 || pend_chk) && t < 5000) begin
      @(negedge clk_i);
      t++;
    end
    if (t >= 5000) check(0, "R2", exp_q.size(), 0, "scan did not drain");
    repeat (30) @(negedge clk_i);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk_i) s = 1'b1;
    @(negedge clk_i) s = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk_i) begin eoc_clr_i = 1; eoic_clr_i = 1; end
    @(negedge clk_i) begin eoc_clr_i = 0; eoic_clr_i = 0; end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    check(0, "R1", 0, 1, "watchdog expired");
    summary();
  end

  initial begin
    int base;
    for (int k = 0; k < RLEN; k++) reg_chans_i[k*CHW +: CHW] = CHW'(rlist[k]);
    for (int k = 0; k < ILEN; k++) ins_chans_i[k*CHW +: CHW] = CHW'(ilist[k]);
    for (int c = 0; c < NCH; c++) smp_code_i[c*SW +: SW] = SW'(code_of(c));

    // R1 reset state
    repeat (3) @(negedge clk_i);
    check(conv_req_o == 0 && dma_req_o == 0, "R1", int'(conv_req_o), 0, "req/dma in reset");
    check(eoc_o == 0 && eoic_o == 0 && eoc_irq_o == 0 && eoic_irq_o == 0, "R1",
          int'({eoc_o, eoic_o, eoc_irq_o, eoic_irq_o}), 0, "flags in reset");
    check(reg_data_o == 0 && ins_data_o == 0, "R1", int'(reg_data_o), 0, "data in reset");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R2 R4 R5 R6 regular scan of 3 by software start
    reg_len_i = 3'd2;
    push_reg(0, 3);
    pulse(reg_sw_start_i);
    wait_drain();
    check(eoc_o == 1, "R5", int'(eoc_o), 1, "eoc after regular");
    check(eoic_o == 0, "R5", int'(eoic_o), 0, "eoic stays clear");
    check(eoc_irq_o == 0, "R6", int'(eoc_irq_o), 0, "irq masked");
    @(negedge clk_i) eoc_ie_i = 1;
    @(negedge clk_i);
    check(eoc_irq_o == 1, "R6", int'(eoc_irq_o), 1, "irq enabled");
    pulse(eoc_clr_i);
    check(eoc_o == 0, "R5", int'(eoc_o), 0, "eoc cleared");
    check(eoc_irq_o == 0, "R6", int'(eoc_irq_o), 0, "irq after clear");

    // R3 inserted scan of 4
    eoic_ie_i = 1;
    ins_len_i = 2'd3;
    push_ins(0, 4);
    pulse(ins_sw_start_i);
    wait_drain();
    check(eoic_o == 1, "R5", int'(eoic_o), 1, "eoic after inserted");
    check(eoic_irq_o == 1, "R6", int'(eoic_irq_o), 1, "inserted irq");
    check(eoc_o == 0, "R5", int'(eoc_o), 0, "eoc untouched by inserted");
    pulse(eoic_clr_i);
    check(eoic_o == 0, "R5", int'(eoic_o), 0, "eoic cleared");

    // R8 external trigger: disabled edge, held level, then real edge
    reg_len_i = 3'd7;
    base = req_rises;
    @(negedge clk_i) reg_ext_trig_i = 1;
    repeat (30) @(negedge clk_i);
    check(req_rises == base, "R8", req_rises - base, 0, "edge with enable low");
    reg_ext_en_i = 1;
    repeat (30) @(negedge clk_i);
    check(req_rises == base, "R8", req_rises - base, 0, "held level");
    push_reg(0, 8);
    @(negedge clk_i) reg_ext_trig_i = 0;
    @(negedge clk_i) reg_ext_trig_i = 1;
    wait_drain();
    check(req_rises == base + 8, "R2", req_rises - base, 8, "eight-entry scan");
    check(eoc_o == 1, "R5", int'(eoc_o), 1, "eoc after eight");
    reg_ext_en_i = 0;
    reg_ext_trig_i = 0;
    clear_flags();

    // R9 inserted preempts regular mid-scan
    reg_len_i = 3'd3;
    ins_len_i = 2'd1;
    push_reg(0, 1);
    push_ins(0, 2);
    push_reg(1, 3);
    pulse(reg_sw_start_i);
    do @(negedge clk_i); while (!conv_req_o);
    ins_sw_start_i = 1;
    @(negedge clk_i) ins_sw_start_i = 0;
    wait_drain();
    check(eoc_o == 1 && eoic_o == 1, "R9", int'({eoc_o, eoic_o}), 3, "both flags after preempt");
    clear_flags();

    // R7 continuous: three passes of two, stop when cont drops
    reg_len_i = 3'd1;
    cont_i = 1;
    base = done_cnt;
    push_reg(0, 2); push_reg(0, 2); push_reg(0, 2);
    pulse(reg_sw_start_i);
    while (done_cnt < base + 5) @(negedge clk_i);
    cont_i = 0;
    wait_drain();
    repeat (40) @(negedge clk_i);
    check(done_cnt == base + 6, "R7", done_cnt - base, 6, "continuous conversions");
    check(eoc_o == 1, "R7", int'(eoc_o), 1, "eoc in continuous");
    clear_flags();

    // R11 trigger while disabled is dropped
    base = req_rises;
    en_i = 0;
    pulse(reg_sw_start_i);
    pulse(ins_sw_start_i);
    repeat (20) @(negedge clk_i);
    en_i = 1;
    repeat (40) @(negedge clk_i);
    check(req_rises == base, "R11", req_rises - base, 0, "no scan after disabled trigger");
    check(eoc_o == 0 && eoic_o == 0, "R11", int'({eoc_o, eoic_o}), 0, "flags untouched");

    summary();
  end
endmodule